// File: doc/BRIEF.md
# Column-First Refresh and Start-Up Sequencer

This block keeps a 4K-row dynamic memory refreshed and runs its power-up start-up sequence. It does not supply row addresses. Each refresh cycle lowers the column strobe before the row strobe, and the memory advances its own internal row counter. The address bus is left alone during refresh. The block shares the strobes with an access sequencer through a request/grant pair. It drives the strobes only after it has sampled the grant high, and it raises a strobe-ownership flag so that the access sequencer can multiplex the pins.

After reset the block stays silent for a parameterised pause, which is 200 µs at the default 200 MHz clock. It then queues a fixed number of start-up refresh cycles (eight by default). When the last of them completes, it raises a ready flag that stays high until the next reset. From then on an interval timer adds one pending refresh every interval (15.6 µs by default; a 31.2 µs setting suits the low-power variant). Missed intervals pile up in a saturating pending counter. When that counter is full, the block asks the access sequencer to stop accepting new accesses until the backlog drains.

All strobe timings are counted in clock cycles and set by parameters. The defaults at 5 ns per cycle are: column lead of 1 cycle, column hold of 2 cycles, row-low time of 9 cycles and precharge of 5 cycles.

Top module: `cbr_refresh_seq`

## Requirements
- R1: While reset is high, ready, ref_req, acc_block and strobe_own are 0, and ras_n, cas_n and we_n are 1.
- R2: During the first PAUSE_CYC cycles after reset is released, ref_req and strobe_own stay 0.
- R3: After the pause, exactly INIT_REFRESHES refresh cycles run. Ready rises only after the last of them and then stays 1 until reset.
- R4: strobe_own rises only in the cycle after ref_gnt was sampled high with work pending. Without a grant the block leaves ras_n and cas_n at 1, even when a refresh is waiting.
- R5: In every refresh, cas_n goes low while ras_n is high, exactly CAS_LEAD_CYC cycles before ras_n falls. we_n stays 1 throughout.
- R6: ras_n stays low for exactly ROW_LOW_CYC cycles. cas_n stays low for the first CAS_HOLD_CYC of those cycles and then returns to 1.
- R7: Between a rise of ras_n and the next fall of ras_n there are at least PRECH_CYC cycles in which both strobes are 1.
- R8: Once ready is high, one pending refresh is added every INTERVAL_CYC cycles, the first one INTERVAL_CYC cycles after ready rises. Each completed refresh removes one. If an addition and a completion fall in the same cycle, the count is unchanged, so over time refreshes equal intervals minus dropped ones.
- R9: The pending count saturates at PEND_MAX, and an interval that arrives while it is full is dropped. acc_block is 1 exactly while ready is high and the count equals PEND_MAX.
- R10: While the grant is held, refresh cycles run back to back until the count reaches zero. ref_req is 1 while work is pending or a cycle is in progress, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Strobe grant from the access sequencer |
| ref_req | output | 1 | Refresh work pending or in progress |
| acc_block | output | 1 | Pending backlog full; new accesses must be held off |
| strobe_own | output | 1 | Block is driving the strobes this cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high for refresh |
| ready | output | 1 | Start-up sequence complete |

## Verification
The interval timer can add a pending refresh in the same cycle that a finishing refresh removes one. A wrong priority there gains or loses a refresh without any visible error. The bench therefore sweeps the cycle at which it raises the grant across a window of about thirty cycles around each interval boundary, so that the completion lands before, on and after the timer edge. It then mixes in randomly timed grants. It judges the result by conservation: at a mid-interval point, the number of observed refreshes plus the one interval deliberately dropped in the saturation test must equal the number of elapsed intervals.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ROW,
        ST_PRECH
    } strobe_st_t;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_INIT,
        PH_RUN
    } phase_t;

    typedef struct packed {
        logic own;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_drv_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // bits needed to hold values 0..n
    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cbr_period_timer.sv
module cbr_period_timer
    import cbr_refresh_pkg::*;
#(
    parameter int unsigned LIMIT = 3120
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int unsigned W = bits_for(LIMIT - 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign tick = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cbr_pending_ctr.sv
module cbr_pending_ctr
    import cbr_refresh_pkg::*;
#(
    parameter int unsigned MAX_PEND  = 8,
    parameter int unsigned INIT_LOAD = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic inc,
    input  logic dec,
    output logic nonzero,
    output logic full
);
    localparam int unsigned W = bits_for(max2(MAX_PEND, INIT_LOAD));
    localparam logic [W-1:0] TOP  = W'(MAX_PEND);
    localparam logic [W-1:0] LOAD = W'(INIT_LOAD);

    logic [W-1:0] count;
    logic         add_ok;

    assign full    = (count >= TOP);
    assign nonzero = (count != '0);
    assign add_ok  = inc && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= LOAD;
        end else begin
            unique case ({add_ok, dec})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/cbr_strobe_fsm.sv
module cbr_strobe_fsm
    import cbr_refresh_pkg::*;
#(
    parameter int unsigned CAS_LEAD_CYC = 1,
    parameter int unsigned CAS_HOLD_CYC = 2,
    parameter int unsigned ROW_LOW_CYC  = 9,
    parameter int unsigned PRECH_CYC    = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        gnt,
    input  logic        pend_nz,
    output strobe_drv_t drv,
    output logic        done
);
    localparam int unsigned CW = bits_for(max2(max2(CAS_LEAD_CYC, ROW_LOW_CYC), PRECH_CYC));
    localparam logic [CW-1:0] SETUP_LAST = CW'(CAS_LEAD_CYC - 1);
    localparam logic [CW-1:0] ROW_LAST   = CW'(ROW_LOW_CYC - 1);
    localparam logic [CW-1:0] PRECH_LAST = CW'(PRECH_CYC - 1);
    localparam logic [CW-1:0] HOLD_END   = CW'(CAS_HOLD_CYC);

    strobe_st_t    st;
    logic [CW-1:0] cnt;

    assign done = (st == ST_PRECH) && (cnt == PRECH_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (gnt && pend_nz) st <= ST_SETUP;
                end
                ST_SETUP: begin
                    if (cnt == SETUP_LAST) begin
                        st  <= ST_ROW;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ROW: begin
                    if (cnt == ROW_LAST) begin
                        st  <= ST_PRECH;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PRECH: begin
                    if (done) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    st  <= ST_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    always_comb begin
        drv = '{own: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        unique case (st)
            ST_IDLE:  drv.own   = 1'b0;
            ST_SETUP: drv.cas_n = 1'b0;
            ST_ROW: begin
                drv.ras_n = 1'b0;
                drv.cas_n = (cnt < HOLD_END) ? 1'b0 : 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq
    import cbr_refresh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC      = 40000,
    parameter int unsigned INTERVAL_CYC   = 3120,
    parameter int unsigned INIT_REFRESHES = 8,
    parameter int unsigned PEND_MAX       = 8,
    parameter int unsigned CAS_LEAD_CYC   = 1,
    parameter int unsigned CAS_HOLD_CYC   = 2,
    parameter int unsigned ROW_LOW_CYC    = 9,
    parameter int unsigned PRECH_CYC      = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt,
    output logic ref_req,
    output logic acc_block,
    output logic strobe_own,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic ready
);
    localparam int unsigned IW = bits_for(INIT_REFRESHES);
    localparam logic [IW-1:0] INIT_LAST = IW'(INIT_REFRESHES - 1);

    phase_t      phase;
    logic [IW-1:0] init_cnt;
    logic        pause_tick, period_tick;
    logic        pend_nz, pend_full, done;
    strobe_drv_t drv;

    cbr_period_timer #(.LIMIT(PAUSE_CYC)) u_pause (
        .clk(clk), .rst(rst), .en(phase == PH_PAUSE), .tick(pause_tick)
    );

    cbr_period_timer #(.LIMIT(INTERVAL_CYC)) u_period (
        .clk(clk), .rst(rst), .en(phase == PH_RUN), .tick(period_tick)
    );

    cbr_pending_ctr #(.MAX_PEND(PEND_MAX), .INIT_LOAD(INIT_REFRESHES)) u_pend (
        .clk(clk), .rst(rst), .load(pause_tick), .inc(period_tick), .dec(done),
        .nonzero(pend_nz), .full(pend_full)
    );

    cbr_strobe_fsm #(
        .CAS_LEAD_CYC(CAS_LEAD_CYC), .CAS_HOLD_CYC(CAS_HOLD_CYC),
        .ROW_LOW_CYC(ROW_LOW_CYC), .PRECH_CYC(PRECH_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst), .gnt(ref_gnt), .pend_nz(pend_nz), .drv(drv), .done(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_PAUSE;
            init_cnt <= '0;
        end else begin
            unique case (phase)
                PH_PAUSE: if (pause_tick) phase <= PH_INIT;
                PH_INIT: begin
                    if (done) begin
                        init_cnt <= init_cnt + 1'b1;
                        if (init_cnt == INIT_LAST) phase <= PH_RUN;
                    end
                end
                default: phase <= PH_RUN;
            endcase
        end
    end

    assign ready      = (phase == PH_RUN);
    assign ref_req    = pend_nz || drv.own;
    assign acc_block  = ready && pend_full;
    assign strobe_own = drv.own;
    assign ras_n      = drv.ras_n;
    assign cas_n      = drv.cas_n;
    assign we_n       = drv.we_n;
endmodule

// File: rtl/cbr_refresh_chk.sv
module cbr_refresh_chk
    import cbr_refresh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC   = 40000,
    parameter int unsigned ROW_LOW_CYC = 9,
    parameter int unsigned PRECH_CYC   = 5
) (
    input logic clk,
    input logic rst,
    input logic ref_gnt,
    input logic ref_req,
    input logic acc_block,
    input logic strobe_own,
    input logic ras_n,
    input logic cas_n,
    input logic ready
);
    localparam int unsigned SW = bits_for(PAUSE_CYC);

    logic [SW-1:0] since;
    logic [7:0]    low_len;
    logic [7:0]    hi_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            since   <= '0;
            low_len <= '0;
            hi_len  <= '0;
        end else begin
            if (since < SW'(PAUSE_CYC)) since <= since + 1'b1;
            low_len <= ras_n ? 8'd0 : low_len + 8'd1;
            if (!ras_n)                        hi_len <= 8'd0;
            else if (cas_n && hi_len != 8'hFF) hi_len <= hi_len + 8'd1;
        end
    end

    assert_pause_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (since < SW'(PAUSE_CYC)) |-> (!ref_req && !strobe_own));

    assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    assert_idle_strobes_R4: assert property (@(posedge clk) disable iff (rst)
        !strobe_own |-> (ras_n && cas_n));

    assert_start_granted_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_own) |-> $past(ref_gnt));

    assert_col_first_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> !$past(cas_n));

    assert_row_width_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (low_len == 8'(ROW_LOW_CYC)));

    assert_precharge_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (hi_len >= 8'(PRECH_CYC)));

    assert_block_req_R9: assert property (@(posedge clk) disable iff (rst)
        acc_block |-> (ref_req && ready));
endmodule

bind cbr_refresh_seq cbr_refresh_chk #(
    .PAUSE_CYC(PAUSE_CYC), .ROW_LOW_CYC(ROW_LOW_CYC), .PRECH_CYC(PRECH_CYC)
) u_chk (
    .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .acc_block(acc_block), .strobe_own(strobe_own), .ras_n(ras_n),
    .cas_n(cas_n), .ready(ready)
);

// File: tb/cbr_refresh_seq_bench.sv
`timescale 1ns/1ps
module cbr_refresh_seq_bench;
    localparam int PAUSE   = 300;
    localparam int PERIOD  = 1000;
    localparam int NINIT   = 8;
    localparam int PMAX    = 8;
    localparam int LEAD    = 1;
    localparam int HOLD    = 2;
    localparam int ROWLOW  = 9;
    localparam int PRECH   = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_gnt = 1'b0;
    logic ref_req, acc_block, strobe_own, ras_n, cas_n, we_n, ready;

    always #2.5 clk = ~clk;

    cbr_refresh_seq #(
        .PAUSE_CYC(PAUSE), .INTERVAL_CYC(PERIOD), .INIT_REFRESHES(NINIT),
        .PEND_MAX(PMAX), .CAS_LEAD_CYC(LEAD), .CAS_HOLD_CYC(HOLD),
        .ROW_LOW_CYC(ROWLOW), .PRECH_CYC(PRECH)
    ) u_cbr_refresh_seq (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .acc_block(acc_block), .strobe_own(strobe_own), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ready(ready)
    );

    int nchk = 0, nfail = 0;
    int sim_cyc, cyc_r, first_fall, ref_total, ref_run;
    int cas_lead, low_len, cas_after, hi_gap;
    int block_outside, we_bad, ready_dropped;
    bit prev_ras, prev_own, prev_gnt, ready_seen, sat_win;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // cycle-level monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            sim_cyc = 0; cyc_r = 0; first_fall = -1; ref_total = 0; ref_run = 0;
            cas_lead = 0; low_len = 0; cas_after = 0; hi_gap = 1000;
            block_outside = 0; we_bad = 0; ready_dropped = 0;
            prev_ras = 1; prev_own = 0; prev_gnt = 0; ready_seen = 0;
        end else begin
            sim_cyc++;
            if (ready) cyc_r++;
            if (ready_seen && !ready) ready_dropped++;
            if (ready && !ready_seen)
                check(ref_total == NINIT, "R3 init refreshes before ready", ref_total, NINIT);
            if (ready) ready_seen = 1;
            if (acc_block && !sat_win) block_outside++;
            if (strobe_own && !we_n) we_bad++;
            if (strobe_own && !prev_own)
                check(prev_gnt, "R4 start without grant", 0, 1);
            if (prev_ras && !ras_n) begin
                ref_total++;
                if (ready) ref_run++;
                if (first_fall < 0) first_fall = sim_cyc;
                check(cas_lead == LEAD, "R5 column lead", cas_lead, LEAD);
                check(we_n == 1'b1, "R5 write enable high", we_n, 1);
                check(hi_gap >= PRECH, "R7 precharge gap", hi_gap, PRECH);
            end
            if (!prev_ras && ras_n) begin
                check(low_len == ROWLOW, "R6 row low width", low_len, ROWLOW);
                check(cas_after == HOLD, "R6 column hold", cas_after, HOLD);
                low_len = 0; cas_after = 0;
            end
            if (!ras_n) begin
                low_len++;
                if (!cas_n) cas_after++;
                hi_gap = 0;
            end else if (cas_n) begin
                if (hi_gap < 1000) hi_gap++;
            end
            if (ras_n && !cas_n) cas_lead++;
            else if (cas_n) cas_lead = 0;
            prev_ras = ras_n; prev_own = strobe_own; prev_gnt = ref_gnt;
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic drain(input string tag);
        int guard = 0;
        while ((ref_req || strobe_own) && guard < 2000) begin
            cyc(1);
            guard++;
        end
        check(guard < 2000, tag, guard, 0);
    endtask

    function automatic int elapsed_ticks(input int r);
        return r / PERIOD;
    endfunction

    initial begin
        int seed;
        int base;
        seed = $urandom(32'd2024);
        sat_win = 0;
        cyc(4);
        // R1 reset state
        check(!ready && !ref_req && !acc_block && !strobe_own, "R1 flags in reset",
              {ready, ref_req, acc_block, strobe_own}, 0);
        check(ras_n && cas_n && we_n, "R1 strobes in reset", {ras_n, cas_n, we_n}, 7);
        rst = 0;
        cyc(PAUSE - 20);
        check(!ref_req && !strobe_own, "R2 quiet during pause", {ref_req, strobe_own}, 0);
        cyc(70);
        check(ref_req == 1'b1, "R4 request without grant", ref_req, 1);
        check(!strobe_own && ref_total == 0, "R4 no strobes without grant", ref_total, 0);
        ref_gnt = 1;
        begin
            int g = 0;
            while (!ready && g < 2000) begin
                cyc(1);
                g++;
            end
        end
        check(ready == 1'b1, "R3 ready rises", ready, 1);
        check(first_fall >= PAUSE + 50, "R4 first refresh waits for grant", first_fall, PAUSE + 50);
        ref_gnt = 0;
        cyc(2);
        check(ref_req == 1'b0, "R10 request drops when drained", ref_req, 0);

        // saturation
        while (cyc_r < 7500) cyc(1);
        check(ref_req && !acc_block, "R9 below limit no block", acc_block, 0);
        sat_win = 1;
        while (cyc_r < 9300) cyc(1);
        check(acc_block == 1'b1, "R9 block at limit", acc_block, 1);
        base = ref_run;
        ref_gnt = 1;
        drain("R10 burst drain");
        ref_gnt = 0;
        check(ref_run - base == PMAX, "R9 burst length (one interval dropped)", ref_run - base, PMAX);
        cyc(1);
        check(acc_block == 1'b0, "R9 block clears", acc_block, 0);
        sat_win = 0;

        // R8 completion/tick coincidence sweep
        for (int d = 0; d < 32; d++) begin
            int t = (PERIOD - 15 + d) % PERIOD;
            do cyc(1); while (cyc_r % PERIOD != t);
            ref_gnt = 1;
            drain("R8 sweep drain");
            ref_gnt = 0;
        end

        // random grant timing
        for (int k = 0; k < 16; k++) begin
            cyc(($urandom % 1800) + 1);
            ref_gnt = 1;
            drain("R10 random drain");
            ref_gnt = 0;
        end

        ref_gnt = 1;
        do cyc(1); while (cyc_r % PERIOD != PERIOD / 2);
        check(ref_req == 1'b0, "R10 idle mid-interval", ref_req, 0);
        check(ref_run + 1 == elapsed_ticks(cyc_r), "R8 refreshes conserve intervals",
              ref_run + 1, elapsed_ticks(cyc_r));
        check(ready == 1'b1 && ready_dropped == 0, "R3 ready sticky", ready_dropped, 0);
        check(we_bad == 0, "R5 write enable during refresh", we_bad, 0);
        check(block_outside == 0, "R9 block outside saturation", block_outside, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule